// File: doc/BRIEF.md
# Segment Register Load Checker

This unit decides whether a protected-mode selector may be placed into a data segment register or into the stack segment register. A request brings a 16-bit selector, a flag that marks the stack register as the target, and the current privilege level. The unit locates the descriptor in either the local or the global table and rejects any selector whose entry lies beyond that table's limit. It then reads the two descriptor words through a single-access memory port and applies the type, privilege and presence rules of the chosen target.

When every check passes, the unit marks the descriptor as accessed in memory, if it is not already marked, and returns both words. When a check fails, it returns exactly one fault class and an error code. A null selector is accepted for data targets without touching memory.

A surrounding execution unit raises a request whenever it is idle and waits for the one-cycle completion strobe. It then either loads its segment cache from the returned words or takes the reported exception.

Top module: `segLoadChk`

## Requirements
- R1: A selector whose bits 15..2 are all zero is null. For a data target the request completes with no fault, both descriptor outputs zero and no memory access. For the stack target it completes with a general-protection fault (faultType 1) and errCode 0, with no memory access.
- R2: Selector bit 2 set picks the local table (ldtBase/ldtLimit) and clear picks the global table. The low word is read at base + (selector & 0xFFF8) and then the high word at that address + 4, in that order.
- R3: If (selector & 0xFFF8) + 7 exceeds the chosen limit, the request ends with faultType 1 and errCode = selector & 0xFFFC, with no memory access. An entry whose last byte equals the limit is accepted.
- R4: A high word with bit 12 clear (system descriptor) gives faultType 1.
- R5: For the stack target, a high word with bit 11 set (code) or bit 9 clear (not writable) gives faultType 1. So does an RPL (selector bits 1..0) or a DPL (high word bits 14..13) different from the request privilege.
- R6: For a data target, bit 11 set with bit 9 clear (execute-only code) gives faultType 1. Unless bits 11 and 10 are both set (conforming code), DPL below the request privilege or below RPL gives faultType 1.
- R7: With all earlier checks passed and bit 15 (present) clear, the result is faultType 2 for the stack target and faultType 3 for a data target. Every fault carries errCode = selector & 0xFFFC. A privilege fault takes precedence over absence.
- R8: On success with bit 8 (accessed) clear, the unit writes the high word with bit 8 set to the high word's address before completing, and returns the updated word. With bit 8 set, no write is made.
- R9: Completion is a single-cycle done pulse. During that cycle faultValid is high exactly when faultType is nonzero (0 none, 1 general protection, 2 stack, 3 not present), and on success descLo/descHi carry the words.
- R10: memValid, memAddr, memWrite and memWdata stay steady until memReady is seen. Only one access is outstanding at a time.
- R11: reqValid is ignored while busy is high. The running request completes with its own result, and no extra completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a check (taken when busy is low) |
| reqSel | input | 16 | Selector to validate |
| reqStack | input | 1 | Target is the stack segment register |
| reqCpl | input | 2 | Current privilege level |
| ldtBase | input | AW | Local table base address |
| ldtLimit | input | LW | Local table limit |
| gdtBase | input | AW | Global table base address |
| gdtLimit | input | LW | Global table limit |
| busy | output | 1 | A request is in progress |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| memAddr | output | AW | Byte address of the access |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts / completes the access |
| memRdata | input | 32 | Read data, valid with memReady |
| done | output | 1 | One-cycle completion strobe |
| faultValid | output | 1 | A fault is reported |
| faultType | output | 2 | 0 none, 1 general protection, 2 stack, 3 not present |
| errCode | output | 16 | Error code for the fault |
| descLo | output | 32 | Descriptor low word |
| descHi | output | 32 | Descriptor high word (accessed bit as written) |

## Verification
Completion is due a fixed number of clock edges after the accepting edge. A null or out-of-limit selector completes after one edge. A request that reads memory completes after 1 + 2(L+1) + 1 edges when the memory answers L cycles after an access is raised, and a write-back adds L+1 more. The bench derives that count and the expected result from the requirements for each request. It then compares done on every clock after a falling edge, and compares the result fields only in the cycle where done is due. It also records every memory handshake and compares the address sequence and write data with the expected order. Latencies of 0, 1 and 3 are used, and one run pokes reqValid while busy.

// File: rtl/segld_pkg.sv
package segld_pkg;
  typedef enum logic [1:0] {FT_NONE = 2'd0, FT_GP = 2'd1, FT_SS = 2'd2, FT_NP = 2'd3} faultKind_e;

  localparam int ACC_BIT  = 8;
  localparam int RW_BIT   = 9;
  localparam int CONF_BIT = 10;
  localparam int CODE_BIT = 11;
  localparam int SEG_BIT  = 12;
  localparam int DPL_LO   = 13;
  localparam int PRES_BIT = 15;

  typedef struct packed {
    logic capReq;
    logic capLo;
    logic capHi;
    logic setAcc;
    logic latchFault;
    logic descStage;
    logic addrHi;
  } dpCtl_t;

  typedef struct packed {
    logic       isNull;
    logic       limitBad;
    faultKind_e descFault;
    logic       accClear;
    logic       stackTgt;
  } dpStat_t;
endpackage

// File: rtl/segld_dp.sv
module segld_dp
  import segld_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [15:0]   reqSel,
  input  logic          reqStack,
  input  logic [1:0]    reqCpl,
  input  logic [AW-1:0] ldtBase,
  input  logic [LW-1:0] ldtLimit,
  input  logic [AW-1:0] gdtBase,
  input  logic [LW-1:0] gdtLimit,
  input  dpCtl_t        ctl,
  output dpStat_t       stat,
  output logic [AW-1:0] memAddr,
  input  logic [31:0]   memRdata,
  output logic [31:0]   memWdata,
  output logic [31:0]   descLo,
  output logic [31:0]   descHi,
  output faultKind_e    faultType,
  output logic [15:0]   errCode
);
  logic [15:0]   selR;
  logic          stackR;
  logic [1:0]    cplR;
  logic [AW-1:0] baseR;
  logic [LW-1:0] limR;
  logic [31:0]   loR, hiR;
  faultKind_e    ftR;
  logic [15:0]   errR;

  logic [15:0]   offset;
  logic [LW:0]   entryEnd;
  logic [1:0]    rpl, dpl;
  logic          isCode, isConf, rwOk, present;
  faultKind_e    descKind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selR <= '0; stackR <= 1'b0; cplR <= '0; baseR <= '0; limR <= '0;
      loR <= '0; hiR <= '0; ftR <= FT_NONE; errR <= '0;
    end else begin
      if (ctl.capReq) begin
        selR   <= reqSel;
        stackR <= reqStack;
        cplR   <= reqCpl;
        baseR  <= reqSel[2] ? ldtBase : gdtBase;
        limR   <= reqSel[2] ? ldtLimit : gdtLimit;
        loR    <= '0;
        hiR    <= '0;
        ftR    <= FT_NONE;
        errR   <= '0;
      end
      if (ctl.capLo) loR <= memRdata;
      if (ctl.capHi) hiR <= memRdata;
      if (ctl.setAcc) hiR[ACC_BIT] <= 1'b1;
      if (ctl.latchFault) begin
        ftR  <= ctl.descStage ? descKind : FT_GP;
        errR <= {selR[15:2], 2'b00};
      end
    end
  end

  assign offset   = {selR[15:3], 3'b000};
  assign entryEnd = (LW+1)'(offset) + (LW+1)'(7);

  assign rpl     = selR[1:0];
  assign dpl     = hiR[DPL_LO+1:DPL_LO];
  assign isCode  = hiR[CODE_BIT];
  assign isConf  = hiR[CONF_BIT];
  assign rwOk    = hiR[RW_BIT];
  assign present = hiR[PRES_BIT];

  always_comb begin
    descKind = FT_NONE;
    if (!hiR[SEG_BIT]) begin
      descKind = FT_GP;
    end else if (stackR) begin
      if (isCode || !rwOk)                descKind = FT_GP;
      else if (rpl != cplR || dpl != cplR) descKind = FT_GP;
      else if (!present)                  descKind = FT_SS;
    end else begin
      if (isCode && !rwOk)                                   descKind = FT_GP;
      else if (!(isCode && isConf) && (dpl < cplR || dpl < rpl)) descKind = FT_GP;
      else if (!present)                                     descKind = FT_NP;
    end
  end

  assign stat.isNull    = (selR[15:2] == 14'd0);
  assign stat.limitBad  = entryEnd > {1'b0, limR};
  assign stat.descFault = descKind;
  assign stat.accClear  = !hiR[ACC_BIT];
  assign stat.stackTgt  = stackR;

  assign memAddr  = baseR + AW'(offset) + (ctl.addrHi ? AW'(4) : AW'(0));
  assign memWdata = hiR | (32'd1 << ACC_BIT);
  assign descLo   = loR;
  assign descHi   = hiR;
  assign faultType = ftR;
  assign errCode  = errR;

  a_r7_err_low: assert property (@(posedge clk) disable iff (!rstN)
    (ftR != FT_NONE) |-> (errR[1:0] == 2'b00));
endmodule

// File: rtl/segld_ctrl.sv
module segld_ctrl
  import segld_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  dpStat_t stat,
  input  logic    memReady,
  output dpCtl_t  ctl,
  output logic    memValid,
  output logic    memWrite,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_LIMIT, S_RD0, S_RD1, S_CHK, S_WR, S_FIN} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    memValid  = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctl.capReq = 1'b1;
        nextState  = S_LIMIT;
      end
      S_LIMIT: begin
        if (stat.isNull) begin
          ctl.latchFault = stat.stackTgt;
          nextState      = S_FIN;
        end else if (stat.limitBad) begin
          ctl.latchFault = 1'b1;
          nextState      = S_FIN;
        end else begin
          nextState = S_RD0;
        end
      end
      S_RD0: begin
        memValid = 1'b1;
        if (memReady) begin
          ctl.capLo = 1'b1;
          nextState = S_RD1;
        end
      end
      S_RD1: begin
        memValid   = 1'b1;
        ctl.addrHi = 1'b1;
        if (memReady) begin
          ctl.capHi = 1'b1;
          nextState = S_CHK;
        end
      end
      S_CHK: begin
        if (stat.descFault != FT_NONE) begin
          ctl.latchFault = 1'b1;
          ctl.descStage  = 1'b1;
          nextState      = S_FIN;
        end else if (stat.accClear) begin
          nextState = S_WR;
        end else begin
          nextState = S_FIN;
        end
      end
      S_WR: begin
        memValid   = 1'b1;
        memWrite   = 1'b1;
        ctl.addrHi = 1'b1;
        if (memReady) begin
          ctl.setAcc = 1'b1;
          nextState  = S_FIN;
        end
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite)));
endmodule

// File: rtl/segLoadChk.sv
module segLoadChk
  import segld_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [15:0]   reqSel,
  input  logic          reqStack,
  input  logic [1:0]    reqCpl,
  input  logic [AW-1:0] ldtBase,
  input  logic [LW-1:0] ldtLimit,
  input  logic [AW-1:0] gdtBase,
  input  logic [LW-1:0] gdtLimit,
  output logic          busy,
  output logic          memValid,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic          memReady,
  input  logic [31:0]   memRdata,
  output logic          done,
  output logic          faultValid,
  output logic [1:0]    faultType,
  output logic [15:0]   errCode,
  output logic [31:0]   descLo,
  output logic [31:0]   descHi
);
  dpCtl_t     ctl;
  dpStat_t    stat;
  faultKind_e ftKind;

  segld_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat), .memReady(memReady),
    .ctl(ctl), .memValid(memValid), .memWrite(memWrite), .busy(busy), .done(done)
  );

  segld_dp #(.AW(AW), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .reqSel(reqSel), .reqStack(reqStack), .reqCpl(reqCpl),
    .ldtBase(ldtBase), .ldtLimit(ldtLimit), .gdtBase(gdtBase), .gdtLimit(gdtLimit),
    .ctl(ctl), .stat(stat), .memAddr(memAddr), .memRdata(memRdata), .memWdata(memWdata),
    .descLo(descLo), .descHi(descHi), .faultType(ftKind), .errCode(errCode)
  );

  assign faultType  = ftKind;
  assign faultValid = (ftKind != FT_NONE);

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memWdata)));
  a_r8_write_then_done: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |=> done);
  a_r8_write_sets_acc: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> memWdata[ACC_BIT]);
endmodule

// File: tb/segLoadChk_test.sv
module segLoadChk_test;
  localparam logic [31:0] GDT_BASE = 32'h100;
  localparam logic [31:0] GDT_LIM  = 32'h3F;
  localparam logic [31:0] LDT_BASE = 32'h200;
  localparam logic [31:0] LDT_LIM  = 32'h1F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqSel = '0;
  logic reqStack = 1'b0;
  logic [1:0] reqCpl = '0;
  logic busy, memValid, memWrite, memReady, done, faultValid;
  logic [31:0] memAddr, memWdata, memRdata, descLo, descHi;
  logic [1:0] faultType;
  logic [15:0] errCode;

  logic [31:0] mem [0:255];
  int lat = 0;
  int waitCnt = 0;
  logic pend = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [32:0] accLog [$];
  logic [31:0] wrLog [$];
  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  segLoadChk uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSel(reqSel), .reqStack(reqStack),
    .reqCpl(reqCpl), .ldtBase(LDT_BASE), .ldtLimit(LDT_LIM), .gdtBase(GDT_BASE),
    .gdtLimit(GDT_LIM), .busy(busy), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .done(done), .faultValid(faultValid), .faultType(faultType), .errCode(errCode),
    .descLo(descLo), .descHi(descHi)
  );

  assign memReady = memValid && (waitCnt == lat);
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (pend) begin
      vectors++;
      if (memAddr !== pendAddr) begin
        fails++;
        $display("FAIL R10 address moved while waiting: act %h exp %h", memAddr, pendAddr);
      end
    end
    pend     <= memValid && !memReady;
    pendAddr <= memAddr;
    if (memValid && !memReady) waitCnt <= waitCnt + 1;
    else                       waitCnt <= 0;
    if (memValid && memReady) begin
      accLog.push_back({memWrite, memAddr});
      if (memWrite) begin
        mem[memAddr[9:2]] <= memWdata;
        wrLog.push_back(memWdata);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] s, input logic st, input logic [1:0] c,
                       output logic [1:0] k, output logic [15:0] e, output logic [31:0] lo,
                       output logic [31:0] hi, output bit rd, output bit wr, output logic [31:0] aLo);
    logic [31:0] base, lim, off;
    logic [1:0] rpl, dpl;
    bit code, conf, rw, pres;
    k = 0; e = 0; lo = 0; hi = 0; rd = 0; wr = 0;
    base = s[2] ? LDT_BASE : GDT_BASE;
    lim  = s[2] ? LDT_LIM : GDT_LIM;
    off  = {16'd0, s & 16'hFFF8};
    aLo  = base + off;
    if ((s & 16'hFFFC) == 0) begin
      if (st) k = 1;
      return;
    end
    if (off + 7 > lim) begin
      k = 1; e = s & 16'hFFFC;
      return;
    end
    rd = 1;
    lo = mem[aLo[9:2]];
    hi = mem[aLo[9:2] + 1];
    rpl = s[1:0]; dpl = hi[14:13];
    code = hi[11]; conf = hi[10]; rw = hi[9]; pres = hi[15];
    if (!hi[12]) k = 1;
    else if (st) begin
      if (code || !rw) k = 1;
      else if (rpl != c || dpl != c) k = 1;
      else if (!pres) k = 2;
    end else begin
      if (code && !rw) k = 1;
      else if (!(code && conf) && (dpl < c || dpl < rpl)) k = 1;
      else if (!pres) k = 3;
    end
    if (k != 0) e = s & 16'hFFFC;
    else if (!hi[8]) begin wr = 1; hi = hi | 32'h100; end
  endtask

  task automatic runReq(input logic [15:0] s, input logic st, input logic [1:0] c,
                        input int l, input bit poke);
    logic [1:0] k; logic [15:0] e; logic [31:0] lo, hi, aLo;
    bit rd, wr;
    int n;
    model(s, st, c, k, e, lo, hi, rd, wr, aLo);
    n = 1 + (rd ? 2 * (l + 1) + 1 : 0) + (wr ? l + 1 : 0);
    lat = l;
    accLog.delete(); wrLog.delete();
    @(negedge clk);
    reqValid = 1'b1; reqSel = s; reqStack = st; reqCpl = c;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 1; i <= n + 3; i++) begin
      if (poke && i == 1) begin
        reqValid = 1'b1; reqSel = 16'h0000; reqStack = 1'b1; reqCpl = 2'd0;
      end
      @(posedge clk);
      @(negedge clk);
      if (poke && i == 1) reqValid = 1'b0;
      chk(done === (i == n), poke ? "R11 done timing under poke" : "R9 done timing",
          {31'd0, done}, {31'd0, i == n});
      if (i == n) begin
        chk(faultType === k, "R9 faultType", {30'd0, faultType}, {30'd0, k});
        chk(faultValid === (k != 0), "R9 faultValid", {31'd0, faultValid}, {31'd0, k != 0});
        chk(errCode === e, "R7 errCode", {16'd0, errCode}, {16'd0, e});
        if (k == 0) begin
          chk(descLo === lo, "R2 descLo", descLo, lo);
          chk(descHi === hi, "R8 descHi", descHi, hi);
        end
      end
    end
    chk(accLog.size() == (rd ? 2 : 0) + (wr ? 1 : 0), "R3 access count",
        accLog.size(), (rd ? 2 : 0) + (wr ? 1 : 0));
    if (rd && accLog.size() >= 2) begin
      chk(accLog[0] === {1'b0, aLo}, "R2 low word address", accLog[0][31:0], aLo);
      chk(accLog[1] === {1'b0, aLo + 32'd4}, "R2 high word address", accLog[1][31:0], aLo + 4);
    end
    if (wr && accLog.size() == 3) begin
      chk(accLog[2] === {1'b1, aLo + 32'd4}, "R8 write address", accLog[2][31:0], aLo + 4);
      chk(wrLog[0] === hi, "R8 write data", wrLog[0], hi);
    end
  endtask

  task automatic setDesc(input logic [31:0] base, input int idx, input logic [31:0] hi);
    mem[(base >> 2) + idx * 2]     = 32'h0000FFFF + idx;
    mem[(base >> 2) + idx * 2 + 1] = 32'h00CF0000 | hi;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired, no completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    setDesc(GDT_BASE, 1, 32'h9200);
    setDesc(GDT_BASE, 2, 32'hF000);
    setDesc(GDT_BASE, 3, 32'h9800);
    setDesc(GDT_BASE, 4, 32'h9A00);
    setDesc(GDT_BASE, 5, 32'h9E00);
    setDesc(GDT_BASE, 6, 32'hF200);
    setDesc(GDT_BASE, 7, 32'h8200);
    setDesc(LDT_BASE, 0, 32'h1200);
    setDesc(LDT_BASE, 1, 32'hF300);
    setDesc(LDT_BASE, 2, 32'h7200);
    setDesc(LDT_BASE, 3, 32'h9300);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && memValid === 1'b0, "R9 reset state",
        {29'd0, done, busy, memValid}, 32'd0);
    rstN = 1'b1;
    // R1 null selectors
    runReq(16'h0003, 1'b0, 2'd3, 0, 0);
    runReq(16'h0000, 1'b1, 2'd0, 0, 0);
    // R2 and R8: global entry with write-back, then again without
    runReq(16'h0008, 1'b0, 2'd0, 0, 0);
    runReq(16'h0008, 1'b0, 2'd0, 1, 0);
    // R2 local table entries, R3 boundary entry accepted
    runReq(16'h000C, 1'b0, 2'd3, 0, 0);
    runReq(16'h001C, 1'b0, 2'd0, 3, 0);
    // R3 limit faults
    runReq(16'h0024, 1'b0, 2'd0, 0, 0);
    runReq(16'h0043, 1'b0, 2'd3, 0, 0);
    // R4 system descriptor
    runReq(16'h0038, 1'b0, 2'd0, 0, 0);
    // R5 stack rules
    runReq(16'h0018, 1'b1, 2'd0, 0, 0);
    runReq(16'h0013, 1'b1, 2'd3, 0, 0);
    runReq(16'h0030, 1'b1, 2'd3, 0, 0);
    runReq(16'h0033, 1'b1, 2'd3, 1, 0);
    runReq(16'h000B, 1'b1, 2'd3, 0, 0);
    // R6 data target rules
    runReq(16'h0018, 1'b0, 2'd0, 0, 0);
    runReq(16'h0020, 1'b0, 2'd3, 0, 0);
    runReq(16'h0028, 1'b0, 2'd3, 0, 0);
    runReq(16'h0032, 1'b0, 2'd2, 0, 0);
    runReq(16'h000B, 1'b0, 2'd0, 0, 0);
    // R7 absence faults and ordering
    runReq(16'h0004, 1'b1, 2'd0, 0, 0);
    runReq(16'h0004, 1'b0, 2'd0, 3, 0);
    runReq(16'h0007, 1'b0, 2'd3, 0, 0);
    runReq(16'h0017, 1'b1, 2'd3, 0, 0);
    // R10 slow memory, R11 request poked while busy
    runReq(16'h0010, 1'b0, 2'd0, 3, 1);
    runReq(16'h0030, 1'b0, 2'd0, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule